// File: doc/BRIEF.md
# Mailbox Slot Ownership and Destination Control

This block is one mailbox slot that cores use to pass messages to each other. A core claims the slot by writing its own one-hot channel ID into the owner register. While it holds the slot, the owner selects the receiving channels in a destination bitmask and then raises a send strobe. One interrupt line per channel goes high for every selected destination once the strobe has been issued.

The slot itself enforces who may write each register and when. Every bus access carries the one-hot channel ID of the requesting core. The owner may set and clear any destination bit. When the auto-acknowledge mode bit is set, a receiving core may also clear its own bit, which withdraws its interrupt. When the owner releases the slot, every destination bit and the send strobe are wiped in that same cycle, whatever the mode. A core that owns several channel IDs should name only one of them as a destination in any single message.

Top module: `mbx_slot`

## Requirements
- R1: After reset, the owner register, destination bitmask, mode register, send flag and every interrupt line are zero.
- R2: A write to the owner register (word offset 0) is accepted only while the register is zero, and only if the written value has exactly one bit set. Any other write with a non-zero value leaves the register unchanged.
- R3: Writing zero to the owner register releases the slot only when the requester's channel ID matches the owner. A release clears all destination bits and the send flag in the same cycle, in every mode.
- R4: A write to the destination-set port (offset 1) ORs the data into the destination bitmask, but only when the requester is the owner. Other set writes are ignored.
- R5: Writes to the destination-clear port (offset 2) are ignored while the slot is unowned. A write from the owner clears every destination bit written as 1.
- R6: When mode bit 0 (auto-acknowledge) is 0, a destination-clear write from a core other than the owner is ignored.
- R7: When mode bit 0 is 1, a destination-clear write from a core other than the owner clears only the bits that are both written as 1 and set in that requester's channel ID.
- R8: Reading offset 3 returns the destination bitmask. Reading offset 0 returns the owner, and reading offset 4 returns the mode. Reading the set port (1), the clear port (2) and the send port (5) returns zero.
- R9: A mode write (offset 4) takes effect only if the requester is the owner, so the slot must be owned. A release leaves the mode unchanged.
- R10: The owner raises the send flag by writing 1 in bit 0 of offset 5. Interrupt line n is high exactly while destination bit n is set and the send flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word offset of the register |
| bus_chan_i | input | NCH (32) | One-hot channel ID of the requesting core |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data (combinational from state) |
| irq_o | output | NCH (32) | One interrupt line per channel |

## Verification
A corrupted owner register would show up at the next read of offset 0. It would also show up as writes that are accepted or refused against the ownership rules, visible in the status read one cycle after the write. A destination bit that is wrong, or a send flag that does not clear on release, appears on irq_o right after the clock edge that committed the faulty update. The scoreboard probes both the status read and the interrupt lines after each rule-relevant write, so a fault in either is reported within one access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_OWNER = 3'd0,
    A_DSET  = 3'd1,
    A_DCLR  = 3'd2,
    A_DSTAT = 3'd3,
    A_MODE  = 3'd4,
    A_SEND  = 3'd5
  } mbx_addr_e;

  function automatic logic is_onehot(input logic [63:0] v);
    return (v != 64'd0) && ((v & (v - 64'd1)) == 64'd0);
  endfunction
endpackage

// File: rtl/mbx_owner_reg.sv
module mbx_owner_reg #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic           upper_nz_i,
  input  logic [NCH-1:0] req_chan_i,
  output logic [NCH-1:0] owner_o,
  output logic           owned_o,
  output logic           is_owner_o,
  output logic           release_o
);
  logic [NCH-1:0] owner_q;
  logic           claim_ok;
  logic [63:0]    wide;

  always_comb begin
    wide = '0;
    wide[NCH-1:0] = wdata_i;
  end

  assign owned_o    = |owner_q;
  assign is_owner_o = |(req_chan_i & owner_q);
  assign claim_ok   = wr_i && !owned_o && !upper_nz_i && mbx_pkg::is_onehot(wide);
  assign release_o  = wr_i && is_owner_o && !upper_nz_i && (wdata_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        owner_q <= '0;
    else if (claim_ok)  owner_q <= wdata_i;
    else if (release_o) owner_q <= '0;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/mbx_dest_reg.sv
module mbx_dest_reg #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic [NCH-1:0] req_chan_i,
  input  logic           owned_i,
  input  logic           is_owner_i,
  input  logic           auto_ack_i,
  input  logic           release_i,
  output logic [NCH-1:0] dest_o
);
  logic [NCH-1:0] dest_q, set_mask, clr_mask;

  always_comb begin
    set_mask = (set_i && is_owner_i) ? wdata_i : '0;
    clr_mask = '0;
    if (clr_i && owned_i) begin
      if (is_owner_i)      clr_mask = wdata_i;
      else if (auto_ack_i) clr_mask = wdata_i & req_chan_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dest_q <= '0;
    else if (release_i) dest_q <= '0;
    else                dest_q <= (dest_q | set_mask) & ~clr_mask;
  end

  assign dest_o = dest_q;
endmodule

// File: rtl/mbx_ctrl_reg.sv
module mbx_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic send_wr_i,
  input  logic wbit0_i,
  input  logic is_owner_i,
  input  logic release_i,
  output logic auto_ack_o,
  output logic sent_o
);
  logic mode_q, sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      if (mode_wr_i && is_owner_i) mode_q <= wbit0_i;
      if (release_i)                             sent_q <= 1'b0;
      else if (send_wr_i && is_owner_i && wbit0_i) sent_q <= 1'b1;
    end
  end

  assign auto_ack_o = mode_q;
  assign sent_o     = sent_q;
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_valid_i,
  input  logic                      bus_write_i,
  input  logic [mbx_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [NCH-1:0]            bus_chan_i,
  input  logic [DW-1:0]             bus_wdata_i,
  output logic [DW-1:0]             bus_rdata_o,
  output logic [NCH-1:0]            irq_o
);
  import mbx_pkg::*;

  logic           wr_owner, wr_set, wr_clr, wr_mode, wr_send, wr_en;
  logic [NCH-1:0] owner, dest, wnch;
  logic           owned, is_owner, release_p, auto_ack, sent, upper_nz;
  mbx_addr_e      addr;

  assign addr     = mbx_addr_e'(bus_addr_i);
  assign wr_en    = bus_valid_i && bus_write_i;
  assign wr_owner = wr_en && (addr == A_OWNER);
  assign wr_set   = wr_en && (addr == A_DSET);
  assign wr_clr   = wr_en && (addr == A_DCLR);
  assign wr_mode  = wr_en && (addr == A_MODE);
  assign wr_send  = wr_en && (addr == A_SEND);
  assign wnch     = bus_wdata_i[NCH-1:0];

  generate
    if (DW > NCH) begin : g_upper
      assign upper_nz = |bus_wdata_i[DW-1:NCH];
    end else begin : g_noupper
      assign upper_nz = 1'b0;
    end
  endgenerate

  mbx_owner_reg #(.NCH(NCH)) u_owner (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_owner), .wdata_i(wnch),
    .upper_nz_i(upper_nz), .req_chan_i(bus_chan_i), .owner_o(owner),
    .owned_o(owned), .is_owner_o(is_owner), .release_o(release_p)
  );

  mbx_dest_reg #(.NCH(NCH)) u_dest (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wr_set), .clr_i(wr_clr),
    .wdata_i(wnch), .req_chan_i(bus_chan_i), .owned_i(owned),
    .is_owner_i(is_owner), .auto_ack_i(auto_ack), .release_i(release_p),
    .dest_o(dest)
  );

  mbx_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(wr_mode), .send_wr_i(wr_send),
    .wbit0_i(bus_wdata_i[0]), .is_owner_i(is_owner), .release_i(release_p),
    .auto_ack_o(auto_ack), .sent_o(sent)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      unique case (addr)
        A_OWNER: bus_rdata_o[NCH-1:0] = owner;
        A_DSTAT: bus_rdata_o[NCH-1:0] = dest;
        A_MODE:  bus_rdata_o[0]       = auto_ack;
        default: bus_rdata_o          = '0;
      endcase
    end
  end

  assign irq_o = dest & {NCH{sent}};
endmodule

// File: rtl/mbx_slot_chk.sv
module mbx_slot_chk #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_valid_i,
  input logic                       bus_write_i,
  input logic [mbx_pkg::ADDR_W-1:0] bus_addr_i,
  input logic [NCH-1:0]             bus_chan_i,
  input logic [NCH-1:0]             owner,
  input logic [NCH-1:0]             dest,
  input logic                       auto_ack,
  input logic [NCH-1:0]             irq_o
);
  logic nonown;
  assign nonown = ~|(bus_chan_i & owner);

  // R2
  owner_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner));

  // R3
  release_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner == '0) |-> (dest == '0));

  // R6
  nonauto_clr_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == 3'd2 && nonown && !auto_ack)
      |=> $stable(dest));

  // R9
  mode_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_addr_i == 3'd4 && nonown)
      |=> $stable(auto_ack));

  // R10
  irq_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~dest) == '0);
endmodule

bind mbx_slot mbx_slot_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i), .bus_chan_i(bus_chan_i),
  .owner(owner), .dest(dest), .auto_ack(auto_ack), .irq_o(irq_o)
);

// File: tb/sim_mbx_slot.sv
`timescale 1ns/1ps
module sim_mbx_slot;
  localparam int NCH = 32;
  localparam int DW  = 32;
  localparam logic [31:0] CA = 32'h1, CB = 32'h20, CC = 32'h200;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [NCH-1:0] bus_chan = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] irq;
  logic irq_probe = 1'b0;
  logic done = 1'b0;

  int checks = 0, errors = 0;
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #2 clk = ~clk;

  mbx_slot #(.NCH(NCH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid),
    .bus_write_i(bus_write), .bus_addr_i(bus_addr), .bus_chan_i(bus_chan),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    if ((bus_valid && !bus_write) || irq_probe) begin
      if (kind_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL scoreboard: result with no expectation");
      end else begin
        int k; logic [31:0] e, a; string r;
        k = kind_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
        a = (k == 0) ? bus_rdata : irq;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: %s actual=%h expected=%h", r, (k == 0) ? "rdata" : "irq", a, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] ch, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_chan = ch; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] ch, input logic [31:0] e, input string r);
    kind_q.push_back(0); exp_q.push_back(e); req_q.push_back(r);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_chan = ch; bus_wdata = '0;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic irq_chk(input logic [31:0] e, input string r);
    kind_q.push_back(1); exp_q.push_back(e); req_q.push_back(r);
    irq_probe = 1'b1;
    @(posedge clk); #1;
    irq_probe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      if (kind_q.size() != 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: %0d expectations left actual=%0d expected=0", kind_q.size(), kind_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    // R1 reset
    rd(3'd0, CA, 32'h0, "R1 owner");
    rd(3'd3, CA, 32'h0, "R1 dest");
    rd(3'd4, CA, 32'h0, "R1 mode");
    irq_chk(32'h0, "R1 irq");
    // R9 mode write while unowned
    wr(3'd4, CA, 32'h1);
    rd(3'd4, CA, 32'h0, "R9 unowned mode");
    // R5 clear while unowned ignored (state stays zero)
    wr(3'd2, CA, 32'hFFFF_FFFF);
    rd(3'd3, CA, 32'h0, "R5 unowned clear");
    // R2 claim
    wr(3'd0, CA, 32'h3);
    rd(3'd0, CA, 32'h0, "R2 non-onehot");
    wr(3'd0, CA, CA);
    rd(3'd0, CA, CA, "R2 claim");
    wr(3'd0, CB, CB);
    rd(3'd0, CB, CA, "R2 held");
    // R4
    wr(3'd1, CB, CB);
    rd(3'd3, CB, 32'h0, "R4 non-owner set");
    wr(3'd1, CA, CB | CC);
    rd(3'd3, CA, CB | CC, "R4 owner set");
    irq_chk(32'h0, "R10 no send");
    // R10
    wr(3'd5, CA, 32'h1);
    irq_chk(CB | CC, "R10 sent");
    // R6
    wr(3'd2, CB, CB);
    rd(3'd3, CB, CB | CC, "R6 non-auto");
    // R5 owner clears
    wr(3'd2, CA, CC);
    rd(3'd3, CA, CB, "R5 owner clear");
    irq_chk(CB, "R10 after clear");
    // R9 owner sets mode
    wr(3'd4, CB, 32'h1);
    rd(3'd4, CB, 32'h0, "R9 non-owner mode");
    wr(3'd4, CA, 32'h1);
    rd(3'd4, CA, 32'h1, "R9 owner mode");
    // R7
    wr(3'd2, CC, CB);
    rd(3'd3, CC, CB, "R7 foreign bit");
    wr(3'd2, CB, 32'hFFFF_FFFF);
    rd(3'd3, CB, 32'h0, "R7 own bit");
    irq_chk(32'h0, "R7 irq");
    // R8 write-only ports read zero
    wr(3'd1, CA, CA | CC);
    rd(3'd1, CA, 32'h0, "R8 set port");
    rd(3'd2, CA, 32'h0, "R8 clear port");
    rd(3'd5, CA, 32'h0, "R8 send port");
    irq_chk(CA | CC, "R10 set while sent");
    // R3
    wr(3'd0, CB, 32'h0);
    rd(3'd0, CB, CA, "R3 non-owner release");
    wr(3'd0, CA, 32'h0);
    rd(3'd0, CA, 32'h0, "R3 release");
    rd(3'd3, CA, 32'h0, "R3 dest wiped");
    irq_chk(32'h0, "R3 irq");
    rd(3'd4, CA, 32'h1, "R9 mode kept");
    wr(3'd0, CC, CC);
    wr(3'd1, CC, CA);
    rd(3'd3, CC, CA, "R3 reclaim dest");
    irq_chk(32'h0, "R3 send flag wiped");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule